// File: doc/BRIEF.md
# Real-Time Clock Field Formatter

This block sits between a real-time clock's binary calendar counters and the byte registers that software reads and writes. In the read direction it turns binary seconds, minutes, hours, weekday, day of month, month and two-digit year into register bytes. The encoding follows two runtime control bits. One selects packed BCD or plain binary. The other selects 24-hour or 12-hour display, and the 12-hour display carries an afternoon flag in bit 7 of the hours byte.

In the write direction it turns bytes written by software back into binary values under the same two control bits, so that the counters can be loaded. Both directions are purely combinational: one conversion path per field, no latency. The clock and reset inputs only qualify the embedded checks and never touch the data path. Counting and storage of the calendar belong to the surrounding clock block.

Top module: `rtc_time_formatter`

## Requirements
- R1: With `bin_mode_i` = 0, each non-hour encoded byte is packed BCD: tens digit in bits [7:4], ones digit in bits [3:0]. This covers seconds, minutes, weekday, day, month and year.
- R2: With `bin_mode_i` = 1, each non-hour encoded byte equals the binary input value, zero-extended to 8 bits (year reduced as in R5).
- R3: With `hr24_i` = 1, the hours byte encodes the hour 0..23 in the current data mode, and bit 7 is 0.
- R4: With `hr24_i` = 0, bits [6:0] of the hours byte encode hour modulo 12 in the current data mode, so midnight and noon both show 0. Bit 7 is 1 exactly for hours 12..23. The hour input is assumed to be 0..23.
- R5: The year input (0..127) is encoded modulo 100. For example, 100 gives 0x00 in both modes and 127 gives 0x27 in BCD.
- R6: Decode of a non-hour byte gives bits[7:4]*10 + bits[3:0] in BCD mode, with no error for nibbles above 9 (0xFF gives 165). In binary mode it gives the byte unchanged.
- R7: Hour decode with `hr24_i` = 0 clears bit 7, decodes bits [6:0] per R6, and adds 12 when bit 7 was set. With `hr24_i` = 1 the whole byte is decoded per R6, with no stripping (BCD 0x80 gives 80).
- R8: All outputs follow the inputs and the control bits within the same cycle, with no clock edge needed.
- R9: `rst_n` and `clk` have no effect on any output. Outputs track the inputs while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the embedded checks only |
| rst_n | input | 1 | Synchronous active-low reset for the embedded checks only |
| bin_mode_i | input | 1 | 1 = binary data, 0 = packed BCD |
| hr24_i | input | 1 | 1 = 24-hour, 0 = 12-hour with afternoon flag |
| sec_i | input | 6 | Binary seconds |
| min_i | input | 6 | Binary minutes |
| hour_i | input | 5 | Binary hour 0..23 |
| wday_i | input | 3 | Binary weekday |
| mday_i | input | 5 | Binary day of month |
| mon_i | input | 4 | Binary month 1..12 |
| year_i | input | 7 | Binary year 0..127 |
| sec_reg_o | output | 8 | Encoded seconds byte |
| min_reg_o | output | 8 | Encoded minutes byte |
| hour_reg_o | output | 8 | Encoded hours byte |
| wday_reg_o | output | 8 | Encoded weekday byte |
| mday_reg_o | output | 8 | Encoded day byte |
| mon_reg_o | output | 8 | Encoded month byte |
| year_reg_o | output | 8 | Encoded year byte |
| sec_wr_i | input | 8 | Written seconds byte |
| min_wr_i | input | 8 | Written minutes byte |
| hour_wr_i | input | 8 | Written hours byte |
| wday_wr_i | input | 8 | Written weekday byte |
| mday_wr_i | input | 8 | Written day byte |
| mon_wr_i | input | 8 | Written month byte |
| year_wr_i | input | 8 | Written year byte |
| sec_dec_o | output | 8 | Decoded seconds |
| min_dec_o | output | 8 | Decoded minutes |
| hour_dec_o | output | 8 | Decoded hour |
| wday_dec_o | output | 8 | Decoded weekday |
| mday_dec_o | output | 8 | Decoded day |
| mon_dec_o | output | 8 | Decoded month |
| year_dec_o | output | 8 | Decoded year |

## Verification
The bench goes after the hour boundaries 0, 11, 12 and 23 in both hour modes. A formatter that tested the flag at 13 or kept 12 instead of 0 at noon would show a wrong hours byte there. Years 99, 100 and 127 expose a missing modulo-100 step, which would show a tens digit of 10 or more. On the write side, bytes with nibbles above 9, bit-7 bytes in 24-hour mode, and afternoon-flagged bytes in binary mode catch a decoder that clamps digits, strips the flag in the wrong mode, or forgets the 12-hour offset. Mode bits are flipped without a clock edge, and outputs are checked while reset is held, to show that nothing is registered or reset.

// File: rtl/rtcfmt_pkg.sv
// Shared widths and conversion helpers for the clock field formatter.
// Assumes every binary field fits in FIELD_W bits (values up to 127).
package rtcfmt_pkg;

    localparam int FIELD_W = 7;
    localparam int BYTE_W  = 8;

    // Split a value below 100 into packed tens/ones digits.
    function automatic logic [BYTE_W-1:0] pack_digits(input logic [FIELD_W-1:0] v);
        return {4'(v / 7'd10), 4'(v % 7'd10)};
    endfunction

    // Reduce a field value to its two-digit range.
    function automatic logic [FIELD_W-1:0] wrap_century(input logic [FIELD_W-1:0] v);
        return (v >= 7'd100) ? FIELD_W'(v - 7'd100) : v;
    endfunction

    // Weigh the two nibbles of a byte as decimal digits, any nibble value allowed.
    function automatic logic [BYTE_W-1:0] weigh_nibbles(input logic [BYTE_W-1:0] b);
        return BYTE_W'({4'd0, b[7:4]} * 8'd10) + BYTE_W'({4'd0, b[3:0]});
    endfunction

endpackage

// File: rtl/rtcfmt_field_enc.sv
// Encodes one binary calendar field into a register byte.
// Assumes the input value is below 128; it is taken modulo 100 before
// encoding, which only changes the year field. Combinational.
module rtcfmt_field_enc
    import rtcfmt_pkg::*;
#(
    parameter int IN_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bin_mode_i,
    input  logic [IN_W-1:0]   value_i,
    output logic [BYTE_W-1:0] byte_o
);
    localparam int PAD_W = FIELD_W - IN_W;

    logic [FIELD_W-1:0] wide_val;
    logic [FIELD_W-1:0] folded_val;

    // Widen the field and fold it into 0..99.
    always_comb begin
        wide_val   = {{PAD_W{1'b0}}, value_i};
        folded_val = wrap_century(wide_val);
    end

    // Select packed digits or plain binary for the output byte.
    always_comb begin
        if (bin_mode_i) byte_o = {1'b0, folded_val};
        else            byte_o = pack_digits(folded_val);
    end

    AST_DIGITS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !bin_mode_i |-> (byte_o[7:4] <= 4'd9 && byte_o[3:0] <= 4'd9)); // R1
    AST_BIN_BELOW_100: assert property (@(posedge clk) disable iff (!rst_n)
        bin_mode_i |-> (byte_o < 8'd100)); // R5
endmodule

// File: rtl/rtcfmt_hour_enc.sv
// Encodes the binary hour into the hours register byte in 12- or 24-hour
// form. Assumes the hour is 0..23. In 12-hour form bit 7 marks 12..23.
module rtcfmt_hour_enc
    import rtcfmt_pkg::*;
#(
    parameter int HOUR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bin_mode_i,
    input  logic              hr24_i,
    input  logic [HOUR_W-1:0] hour_i,
    output logic [BYTE_W-1:0] byte_o
);
    localparam logic [HOUR_W-1:0] HALF_DAY = HOUR_W'(12);

    logic              afternoon;
    logic [HOUR_W-1:0] shown_hour;
    logic [BYTE_W-1:0] digits;

    // Pick the hour value that is displayed and the afternoon flag.
    always_comb begin
        afternoon  = (hour_i >= HALF_DAY);
        shown_hour = (!hr24_i && afternoon) ? HOUR_W'(hour_i - HALF_DAY) : hour_i;
    end

    rtcfmt_field_enc #(.IN_W(HOUR_W)) u_digits (
        .clk        (clk),
        .rst_n      (rst_n),
        .bin_mode_i (bin_mode_i),
        .value_i    (shown_hour),
        .byte_o     (digits)
    );

    // Merge the flag into bit 7 in 12-hour form only.
    always_comb begin
        byte_o = digits;
        if (!hr24_i) byte_o[7] = afternoon;
    end

    AST_FLAG_ONLY_12H: assert property (@(posedge clk) disable iff (!rst_n)
        hr24_i |-> !byte_o[7]); // R3
    AST_HOUR_BELOW_12: assert property (@(posedge clk) disable iff (!rst_n)
        (!hr24_i && bin_mode_i) |-> (byte_o[6:0] <= 7'd11)); // R4
    AST_BCD_TENS_12H: assert property (@(posedge clk) disable iff (!rst_n)
        (!hr24_i && !bin_mode_i) |-> (byte_o[6:4] <= 3'd1)); // R4
endmodule

// File: rtl/rtcfmt_field_dec.sv
// Decodes one written register byte into a binary value. BCD nibbles are
// weighed as tens/ones with no range check; binary passes through.
module rtcfmt_field_dec
    import rtcfmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bin_mode_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic [BYTE_W-1:0] value_o
);
    // Choose between nibble weighing and pass-through.
    always_comb begin
        if (bin_mode_i) value_o = byte_i;
        else            value_o = weigh_nibbles(byte_i);
    end

    AST_DEC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        !bin_mode_i |-> (value_o <= 8'd165)); // R6
    AST_DEC_VALID_BELOW_100: assert property (@(posedge clk) disable iff (!rst_n)
        (!bin_mode_i && byte_i[7:4] <= 4'd9 && byte_i[3:0] <= 4'd9) |-> (value_o < 8'd100)); // R6
endmodule

// File: rtl/rtcfmt_hour_dec.sv
// Decodes a written hours byte. In 12-hour form bit 7 is the afternoon
// flag: it is cleared before decoding and adds 12 when set.
module rtcfmt_hour_dec
    import rtcfmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bin_mode_i,
    input  logic              hr24_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic [BYTE_W-1:0] value_o
);
    logic [BYTE_W-1:0] body;
    logic [BYTE_W-1:0] body_val;

    // Strip the flag bit in 12-hour form only.
    always_comb begin
        body = byte_i;
        if (!hr24_i) body[7] = 1'b0;
    end

    rtcfmt_field_dec u_body (
        .clk        (clk),
        .rst_n      (rst_n),
        .bin_mode_i (bin_mode_i),
        .byte_i     (body),
        .value_o    (body_val)
    );

    // Add the half-day offset for flagged 12-hour values.
    always_comb begin
        value_o = body_val;
        if (!hr24_i && byte_i[7]) value_o = BYTE_W'(body_val + 8'd12);
    end

    AST_PM_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (!hr24_i && byte_i[7]) |-> (value_o >= 8'd12)); // R7
    AST_AM_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (!hr24_i && !byte_i[7]) |-> (value_o == body_val)); // R7
endmodule

// File: rtl/rtc_time_formatter.sv
// Top of the clock field formatter: one encode path and one decode path
// per calendar field, all combinational. clk/rst_n only qualify checks.
// Assumes the hour input is 0..23 and other inputs fit their widths.
module rtc_time_formatter
    import rtcfmt_pkg::*;
#(
    parameter int SEC_W  = 6,
    parameter int MIN_W  = 6,
    parameter int HOUR_W = 5,
    parameter int WDAY_W = 3,
    parameter int MDAY_W = 5,
    parameter int MON_W  = 4,
    parameter int YEAR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bin_mode_i,
    input  logic              hr24_i,
    input  logic [SEC_W-1:0]  sec_i,
    input  logic [MIN_W-1:0]  min_i,
    input  logic [HOUR_W-1:0] hour_i,
    input  logic [WDAY_W-1:0] wday_i,
    input  logic [MDAY_W-1:0] mday_i,
    input  logic [MON_W-1:0]  mon_i,
    input  logic [YEAR_W-1:0] year_i,
    output logic [7:0]        sec_reg_o,
    output logic [7:0]        min_reg_o,
    output logic [7:0]        hour_reg_o,
    output logic [7:0]        wday_reg_o,
    output logic [7:0]        mday_reg_o,
    output logic [7:0]        mon_reg_o,
    output logic [7:0]        year_reg_o,
    input  logic [7:0]        sec_wr_i,
    input  logic [7:0]        min_wr_i,
    input  logic [7:0]        hour_wr_i,
    input  logic [7:0]        wday_wr_i,
    input  logic [7:0]        mday_wr_i,
    input  logic [7:0]        mon_wr_i,
    input  logic [7:0]        year_wr_i,
    output logic [7:0]        sec_dec_o,
    output logic [7:0]        min_dec_o,
    output logic [7:0]        hour_dec_o,
    output logic [7:0]        wday_dec_o,
    output logic [7:0]        mday_dec_o,
    output logic [7:0]        mon_dec_o,
    output logic [7:0]        year_dec_o
);
    // Non-hour fields share one conversion shape: sec, min, wday, mday, mon, year.
    localparam int NF = 6;

    logic [FIELD_W-1:0] enc_val  [NF];
    logic [BYTE_W-1:0]  enc_byte [NF];
    logic [BYTE_W-1:0]  dec_byte [NF];
    logic [BYTE_W-1:0]  dec_val  [NF];

    // Gather the binary fields, zero-extended, into one array.
    always_comb begin
        enc_val[0] = FIELD_W'(sec_i);
        enc_val[1] = FIELD_W'(min_i);
        enc_val[2] = FIELD_W'(wday_i);
        enc_val[3] = FIELD_W'(mday_i);
        enc_val[4] = FIELD_W'(mon_i);
        enc_val[5] = FIELD_W'(year_i);
    end

    // Gather the written bytes into one array.
    always_comb begin
        dec_byte[0] = sec_wr_i;
        dec_byte[1] = min_wr_i;
        dec_byte[2] = wday_wr_i;
        dec_byte[3] = mday_wr_i;
        dec_byte[4] = mon_wr_i;
        dec_byte[5] = year_wr_i;
    end

    for (genvar f = 0; f < NF; f++) begin : g_field
        rtcfmt_field_enc #(.IN_W(FIELD_W)) u_enc (
            .clk        (clk),
            .rst_n      (rst_n),
            .bin_mode_i (bin_mode_i),
            .value_i    (enc_val[f]),
            .byte_o     (enc_byte[f])
        );
        rtcfmt_field_dec u_dec (
            .clk        (clk),
            .rst_n      (rst_n),
            .bin_mode_i (bin_mode_i),
            .byte_i     (dec_byte[f]),
            .value_o    (dec_val[f])
        );
    end

    rtcfmt_hour_enc #(.HOUR_W(HOUR_W)) u_hour_enc (
        .clk        (clk),
        .rst_n      (rst_n),
        .bin_mode_i (bin_mode_i),
        .hr24_i     (hr24_i),
        .hour_i     (hour_i),
        .byte_o     (hour_reg_o)
    );

    rtcfmt_hour_dec u_hour_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .bin_mode_i (bin_mode_i),
        .hr24_i     (hr24_i),
        .byte_i     (hour_wr_i),
        .value_o    (hour_dec_o)
    );

    // Scatter encoded bytes and decoded values to the ports.
    always_comb begin
        sec_reg_o  = enc_byte[0];
        min_reg_o  = enc_byte[1];
        wday_reg_o = enc_byte[2];
        mday_reg_o = enc_byte[3];
        mon_reg_o  = enc_byte[4];
        year_reg_o = enc_byte[5];
        sec_dec_o  = dec_val[0];
        min_dec_o  = dec_val[1];
        wday_dec_o = dec_val[2];
        mday_dec_o = dec_val[3];
        mon_dec_o  = dec_val[4];
        year_dec_o = dec_val[5];
    end

    AST_YEAR_TWO_DIGITS: assert property (@(posedge clk) disable iff (!rst_n)
        !bin_mode_i |-> (year_reg_o[7:4] <= 4'd9)); // R5
    AST_ROUND_TRIP_SEC: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_wr_i == sec_reg_o) |-> (sec_dec_o == 8'(sec_i))); // R6
endmodule

// File: tb/rtc_time_formatter_test.sv
module rtc_time_formatter_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic       bin_mode, hr24;
    logic [5:0] sec, mnt;
    logic [4:0] hour, mday;
    logic [2:0] wday;
    logic [3:0] mon;
    logic [6:0] year;
    logic [7:0] r_sec, r_min, r_hour, r_wday, r_mday, r_mon, r_year;
    logic [7:0] w_sec, w_min, w_hour, w_wday, w_mday, w_mon, w_year;
    logic [7:0] d_sec, d_min, d_hour, d_wday, d_mday, d_mon, d_year;

    rtc_time_formatter uut (
        .clk(clk), .rst_n(rst_n), .bin_mode_i(bin_mode), .hr24_i(hr24),
        .sec_i(sec), .min_i(mnt), .hour_i(hour), .wday_i(wday),
        .mday_i(mday), .mon_i(mon), .year_i(year),
        .sec_reg_o(r_sec), .min_reg_o(r_min), .hour_reg_o(r_hour),
        .wday_reg_o(r_wday), .mday_reg_o(r_mday), .mon_reg_o(r_mon),
        .year_reg_o(r_year),
        .sec_wr_i(w_sec), .min_wr_i(w_min), .hour_wr_i(w_hour),
        .wday_wr_i(w_wday), .mday_wr_i(w_mday), .mon_wr_i(w_mon),
        .year_wr_i(w_year),
        .sec_dec_o(d_sec), .min_dec_o(d_min), .hour_dec_o(d_hour),
        .wday_dec_o(d_wday), .mday_dec_o(d_mday), .mon_dec_o(d_mon),
        .year_dec_o(d_year)
    );

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    function automatic logic [7:0] ref_enc(input int v, input bit b);
        int m = v % 100;
        return b ? 8'(m) : {4'(m / 10), 4'(m % 10)};
    endfunction

    function automatic logic [7:0] ref_hour_enc(input int h, input bit b, input bit h24);
        logic [7:0] e;
        if (h24) return ref_enc(h, b);
        e = ref_enc(h % 12, b);
        e[7] = (h >= 12);
        return e;
    endfunction

    function automatic logic [7:0] ref_dec(input logic [7:0] x, input bit b);
        return b ? x : 8'(int'(x[7:4]) * 10 + int'(x[3:0]));
    endfunction

    function automatic logic [7:0] ref_hour_dec(input logic [7:0] x, input bit b, input bit h24);
        if (h24) return ref_dec(x, b);
        return 8'(int'(ref_dec({1'b0, x[6:0]}, b)) + (x[7] ? 12 : 0));
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        string m = bin_mode ? "R2" : "R1";
        string h = hr24 ? "R3" : "R4";
        check({m, " sec ", tag}, r_sec, ref_enc(int'(sec), bin_mode));
        check({m, " min ", tag}, r_min, ref_enc(int'(mnt), bin_mode));
        check({m, " wday ", tag}, r_wday, ref_enc(int'(wday), bin_mode));
        check({m, " mday ", tag}, r_mday, ref_enc(int'(mday), bin_mode));
        check({m, " mon ", tag}, r_mon, ref_enc(int'(mon), bin_mode));
        check({"R5 year ", tag}, r_year, ref_enc(int'(year), bin_mode));
        check({h, " hour ", tag}, r_hour, ref_hour_enc(int'(hour), bin_mode, hr24));
        check({"R6 sec dec ", tag}, d_sec, ref_dec(w_sec, bin_mode));
        check({"R6 min dec ", tag}, d_min, ref_dec(w_min, bin_mode));
        check({"R6 wday dec ", tag}, d_wday, ref_dec(w_wday, bin_mode));
        check({"R6 mday dec ", tag}, d_mday, ref_dec(w_mday, bin_mode));
        check({"R6 mon dec ", tag}, d_mon, ref_dec(w_mon, bin_mode));
        check({"R6 year dec ", tag}, d_year, ref_dec(w_year, bin_mode));
        check({"R7 hour dec ", tag}, d_hour, ref_hour_dec(w_hour, bin_mode, hr24));
    endtask

    task automatic randomize_inputs();
        bin_mode = 1'($urandom_range(0, 1));
        hr24     = 1'($urandom_range(0, 1));
        sec  = 6'($urandom_range(0, 59));
        mnt  = 6'($urandom_range(0, 59));
        hour = 5'($urandom_range(0, 23));
        wday = 3'($urandom_range(1, 7));
        mday = 5'($urandom_range(1, 31));
        mon  = 4'($urandom_range(1, 12));
        year = 7'($urandom_range(0, 127));
        w_sec = 8'($urandom); w_min = 8'($urandom); w_hour = 8'($urandom);
        w_wday = 8'($urandom); w_mday = 8'($urandom); w_mon = 8'($urandom);
        w_year = 8'($urandom);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        bin_mode = 1'b0; hr24 = 1'b1;
        sec = 6'd45; mnt = 6'd7; hour = 5'd19; wday = 3'd3; mday = 5'd28;
        mon = 4'd11; year = 7'd24;
        w_sec = 8'h59; w_min = 8'h00; w_hour = 8'h23; w_wday = 8'h07;
        w_mday = 8'h31; w_mon = 8'h12; w_year = 8'h99;
        // R9: outputs track inputs while reset is held
        repeat (2) @(negedge clk);
        #1 check("R9 reset hour", r_hour, 8'h19);
        check("R9 reset sec", r_sec, 8'h45);
        check("R9 reset dec", d_year, 8'd99);
        bin_mode = 1'b1;
        #1 check("R9 reset bin mon", r_mon, 8'd11);
        @(negedge clk); rst_n = 1'b1;

        // R4: hour boundaries in 12-hour BCD
        bin_mode = 1'b0; hr24 = 1'b0;
        hour = 5'd0;  #1 check("R4 midnight", r_hour, 8'h00);
        hour = 5'd11; #1 check("R4 11am", r_hour, 8'h11);
        hour = 5'd12; #1 check("R4 noon", r_hour, 8'h80);
        hour = 5'd23; #1 check("R4 11pm", r_hour, 8'h91);
        bin_mode = 1'b1; #1 check("R4 11pm bin", r_hour, 8'h8B);
        // R8: mode flip without a clock edge
        hr24 = 1'b1; #1 check("R8 R3 23 bin", r_hour, 8'd23);
        bin_mode = 1'b0; #1 check("R8 R3 23 bcd", r_hour, 8'h23);
        hour = 5'd12; #1 check("R3 noon 24h", r_hour, 8'h12);
        // R5: year wrap
        year = 7'd99;  #1 check("R5 99", r_year, 8'h99);
        year = 7'd100; #1 check("R5 100", r_year, 8'h00);
        year = 7'd127; #1 check("R5 127", r_year, 8'h27);
        bin_mode = 1'b1; #1 check("R5 127 bin", r_year, 8'd27);
        // R6/R7: decode corners
        bin_mode = 1'b0; hr24 = 1'b1;
        w_sec = 8'hFF; w_hour = 8'h80;
        #1 check("R6 nibble FF", d_sec, 8'd165);
        check("R7 24h no strip", d_hour, 8'd80);
        hr24 = 1'b0; w_hour = 8'h92;
        #1 check("R7 12h pm bcd", d_hour, 8'd24);
        w_hour = 8'h12; #1 check("R7 12h am bcd", d_hour, 8'd12);
        bin_mode = 1'b1; w_hour = 8'h8B;
        #1 check("R7 12h pm bin", d_hour, 8'd23);
        w_sec = 8'hFF; #1 check("R6 bin pass", d_sec, 8'hFF);
        hr24 = 1'b1; w_hour = 8'hFF; #1 check("R7 24h bin", d_hour, 8'hFF);

        // Random mix across all modes
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            randomize_inputs();
            #1 check_all("rand");
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule